// File: doc/BRIEF.md
# Memory-Driven ADC Conversion List Sequencer

This block runs a list of analog-to-digital conversions that software places in data memory. It then writes every result back over the list entry that asked for it, so the processor does not have to act at each sample. Software loads a 24-bit start address through three byte-wide pointer registers. It enables the sequencer through a control register and then supplies conversion starts. A start comes from a single-shot command bit, a periodic timer tick or a rising edge on an external trigger pin. Each source is gated by its own enable bit.

Each list entry takes two consecutive bytes, and its channel number sits in bits [7:4] of the first byte. Before each conversion the sequencer reads the current entry and the entry after it. The list ends on an entry with channel field 1111. Because of the look-ahead, the entry just before the terminator is never converted. Software therefore repeats the last wanted channel in front of the terminator. After each conversion the 16-bit word {channel, sample} is written high byte first at the entry address. The pointer then steps by two. When the terminator is reached, the busy status drops and a sticky interrupt flag rises. The converter is reached through a start-pulse / done-strobe handshake.

Top module: `adc_list_dma`

## Requirements
- R1: Out of reset busy_o, irq_o, mem_req_o and conv_start_o are low, and while busy_o is low the block issues no memory access and no conversion start.
- R2: Register select 0, 1 and 2 address the low, middle and page bytes of the start pointer. Writes to the low and middle bytes are only staged. A page-byte write commits all three bytes together as the start address. A start with no page write since the staging writes uses the previously committed address.
- R3: A write to register select 3 (control) with bit 0 set, made while busy_o is low, raises busy_o on the next cycle. It then reads the entry at the committed start address and the entry two bytes above it. The channel field is taken from read-data bits [7:4].
- R4: In the wait-for-trigger state, an accepted trigger produces a one-cycle conv_start_o pulse on the next cycle, with conv_chan_o equal to the current entry's channel. The three trigger sources are: control bit 3 in a control write (single shot), timer_tick_i while control bit 1 is set, and a rising edge on ext_trig_i while control bit 2 is set. The external edge passes through a two-stage synchronizer.
- R5: Triggers arriving while a conversion is pending, or while the block is fetching or writing, are ignored: exactly one conversion is started per converted entry.
- R6: When conv_done_i is sampled, the block writes {channel, result[11:8]} to the entry address and result[7:0] to the entry address + 1, on two consecutive cycles. The pointer then advances by 2.
- R7: The sequence stops on reaching an entry whose own channel field, or the following entry's channel field, is 1111. That entry and the following one are neither converted nor written. busy_o falls and irq_o rises in the same cycle.
- R8: irq_o stays set until the next control write, which clears it.
- R9: A control write with bit 0 clear aborts the sequence. busy_o is low on the next cycle, and no further memory write, conversion start or interrupt follows.
- R10: A timer tick while control bit 1 is clear, or an external edge while control bit 2 is clear, starts no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 pointer low, 1 pointer middle, 2 pointer page, 3 control |
| reg_wdata_i | input | 8 | Register write data |
| timer_tick_i | input | 1 | Periodic timer overflow tick |
| ext_trig_i | input | 1 | External conversion trigger (asynchronous) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 24 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after a read request |
| conv_start_o | output | 1 | Conversion start pulse |
| conv_chan_o | output | 4 | Channel of the requested conversion |
| conv_done_i | input | 1 | Conversion done strobe |
| conv_data_i | input | 12 | Conversion sample, valid with conv_done_i |
| busy_o | output | 1 | Sequence active |
| irq_o | output | 1 | Sticky sequence-complete flag |

## Verification
Inputs are driven and outputs sampled on the falling edge, so each result lands in a known cycle. busy_o is checked at the first falling edge after the control write. conv_start_o and conv_chan_o are checked at the first falling edge after a single-shot write made in the wait state. The two result bytes appear on the two cycles after the done strobe. busy_o falls and irq_o rises four cycles after the low-byte write of the last converted entry. Memory images and conversion logs are compared only once busy_o has fallen, while timer ticks arrive faster than conversions end. This checks that no surplus conversion is started and that no entry past the converted ones is written.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;
  localparam int ADDR_W   = 24;
  localparam int BYTE_W   = 8;
  localparam int CHAN_W   = 4;
  localparam int SAMPLE_W = 12;
  localparam int RES_W    = CHAN_W + SAMPLE_W;
  localparam int PTR_BYTES = ADDR_W / BYTE_W;
  localparam int SEL_W    = 2;
  localparam int ENTRY_STRIDE = 2;
  localparam logic [CHAN_W-1:0] STOP_CHAN = '1;

  // control register bits
  localparam int CTRL_EN   = 0;
  localparam int CTRL_TMR  = 1;
  localparam int CTRL_EXT  = 2;
  localparam int CTRL_SHOT = 3;

  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CUR, S_RD_NXT, S_EVAL, S_WAIT_TRIG,
    S_CONV, S_WR_HI, S_WR_LO, S_DONE
  } seq_state_e;
endpackage

// File: rtl/adc_dma_regs.sv
module adc_dma_regs
  import adc_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              ctrl_wr_o,
  output logic              en_set_o,
  output logic              en_clr_o,
  output logic              shot_o,
  output logic              tmr_en_o,
  output logic              ext_en_o
);
  logic [BYTE_W-1:0] stage_q [PTR_BYTES-1];
  logic [ADDR_W-1:0] base_q;
  logic              tmr_en_q, ext_en_q;

  // lower pointer bytes staged; page byte commits the full pointer
  for (genvar b = 0; b < PTR_BYTES - 1; b++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[b] <= '0;
      else if (we_i && sel_i == SEL_W'(b)) stage_q[b] <= wdata_i;
    end
  end

  logic [ADDR_W-1:0] base_d;
  always_comb begin
    base_d = '0;
    base_d[ADDR_W-1 -: BYTE_W] = wdata_i;
    for (int b = 0; b < PTR_BYTES - 1; b++) base_d[b*BYTE_W +: BYTE_W] = stage_q[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      tmr_en_q <= 1'b0;
      ext_en_q <= 1'b0;
    end else if (we_i) begin
      if (sel_i == SEL_W'(PTR_BYTES - 1)) base_q <= base_d;
      if (sel_i == SEL_CTRL) begin
        tmr_en_q <= wdata_i[CTRL_TMR];
        ext_en_q <= wdata_i[CTRL_EXT];
      end
    end
  end

  assign ctrl_wr_o = we_i && (sel_i == SEL_CTRL);
  assign en_set_o  = ctrl_wr_o && wdata_i[CTRL_EN];
  assign en_clr_o  = ctrl_wr_o && !wdata_i[CTRL_EN];
  assign shot_o    = ctrl_wr_o && wdata_i[CTRL_SHOT];
  assign base_o    = base_q;
  assign tmr_en_o  = tmr_en_q;
  assign ext_en_o  = ext_en_q;
endmodule

// File: rtl/adc_dma_trig.sv
module adc_dma_trig #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shot_i,
  input  logic tmr_tick_i,
  input  logic tmr_en_i,
  input  logic ext_i,
  input  logic ext_en_i,
  output logic trig_o
);
  localparam int SH_W = SYNC_STAGES + 1;
  logic [SH_W-1:0] ext_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_sh_q <= '0;
    else         ext_sh_q <= {ext_sh_q[SH_W-2:0], ext_i};
  end

  logic ext_rise;
  assign ext_rise = ext_sh_q[SH_W-2] && !ext_sh_q[SH_W-1];
  assign trig_o   = shot_i || (tmr_en_i && tmr_tick_i) || (ext_en_i && ext_rise);
endmodule

// File: rtl/adc_dma_seq.sv
module adc_dma_seq
  import adc_dma_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic                ctrl_wr_i,
  input  logic                en_set_i,
  input  logic                en_clr_i,
  input  logic                trig_i,
  input  logic [CHAN_W-1:0]   rd_chan_i,
  input  logic                conv_done_i,
  input  logic [SAMPLE_W-1:0] conv_data_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [BYTE_W-1:0]   mem_wdata_o,
  output logic                conv_start_o,
  output logic [CHAN_W-1:0]   conv_chan_o,
  output logic                busy_o,
  output logic                irq_o
);
  seq_state_e st_q, st_d;
  logic [ADDR_W-1:0]   ptr_q;
  logic [CHAN_W-1:0]   cur_q;
  logic [SAMPLE_W-1:0] res_q;
  logic                irq_q, start_q;
  logic                idle_like, stop_hit;
  logic [RES_W-1:0]    word;

  assign idle_like = (st_q == S_IDLE) || (st_q == S_DONE);
  assign stop_hit  = (cur_q == STOP_CHAN) || (rd_chan_i == STOP_CHAN);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:      if (en_set_i) st_d = S_RD_CUR;
      S_RD_CUR:    st_d = S_RD_NXT;
      S_RD_NXT:    st_d = S_EVAL;
      S_EVAL:      st_d = stop_hit ? S_DONE : S_WAIT_TRIG;
      S_WAIT_TRIG: if (trig_i) st_d = S_CONV;
      S_CONV:      if (conv_done_i) st_d = S_WR_HI;
      S_WR_HI:     st_d = S_WR_LO;
      S_WR_LO:     st_d = S_RD_CUR;
      S_DONE:      if (en_set_i) st_d = S_RD_CUR;
      default:     st_d = S_IDLE;
    endcase
    if (en_clr_i) st_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      ptr_q   <= '0;
      cur_q   <= '0;
      res_q   <= '0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= (st_q == S_WAIT_TRIG) && trig_i && !en_clr_i;
      if (idle_like && en_set_i)       ptr_q <= base_i;
      else if (st_q == S_WR_LO)        ptr_q <= ptr_q + ADDR_W'(ENTRY_STRIDE);
      if (st_q == S_RD_NXT)            cur_q <= rd_chan_i;
      if (st_q == S_CONV && conv_done_i) res_q <= conv_data_i;
      if (ctrl_wr_i)                   irq_q <= 1'b0;
      if (st_q == S_EVAL && stop_hit && !en_clr_i) irq_q <= 1'b1;
    end
  end

  assign word = {cur_q, res_q};

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr_q;
    mem_wdata_o = '0;
    unique case (st_q)
      S_RD_CUR: mem_req_o = 1'b1;
      S_RD_NXT: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ptr_q + ADDR_W'(ENTRY_STRIDE);
      end
      S_WR_HI: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = word[RES_W-1 -: BYTE_W];
      end
      S_WR_LO: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr_q + ADDR_W'(1);
        mem_wdata_o = word[BYTE_W-1:0];
      end
      default: ;
    endcase
  end

  assign conv_start_o = start_q;
  assign conv_chan_o  = cur_q;
  assign busy_o       = !idle_like;
  assign irq_o        = irq_q;
endmodule

// File: rtl/adc_list_dma.sv
module adc_list_dma
  import adc_dma_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [SEL_W-1:0]    reg_sel_i,
  input  logic [BYTE_W-1:0]   reg_wdata_i,
  input  logic                timer_tick_i,
  input  logic                ext_trig_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [BYTE_W-1:0]   mem_wdata_o,
  input  logic [BYTE_W-1:0]   mem_rdata_i,
  output logic                conv_start_o,
  output logic [CHAN_W-1:0]   conv_chan_o,
  input  logic                conv_done_i,
  input  logic [SAMPLE_W-1:0] conv_data_i,
  output logic                busy_o,
  output logic                irq_o
);
  logic [ADDR_W-1:0] base;
  logic ctrl_wr, en_set, en_clr, shot, tmr_en, ext_en, trig;
  logic unused_rd_low;

  assign unused_rd_low = ^mem_rdata_i[BYTE_W-CHAN_W-1:0];

  adc_dma_regs i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .base_o(base), .ctrl_wr_o(ctrl_wr), .en_set_o(en_set), .en_clr_o(en_clr),
    .shot_o(shot), .tmr_en_o(tmr_en), .ext_en_o(ext_en)
  );

  adc_dma_trig #(.SYNC_STAGES(SYNC_STAGES)) i_trig (
    .clk_i, .rst_ni,
    .shot_i(shot), .tmr_tick_i(timer_tick_i), .tmr_en_i(tmr_en),
    .ext_i(ext_trig_i), .ext_en_i(ext_en), .trig_o(trig)
  );

  adc_dma_seq i_seq (
    .clk_i, .rst_ni,
    .base_i(base), .ctrl_wr_i(ctrl_wr), .en_set_i(en_set), .en_clr_i(en_clr),
    .trig_i(trig), .rd_chan_i(mem_rdata_i[BYTE_W-1 -: CHAN_W]),
    .conv_done_i, .conv_data_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .conv_start_o, .conv_chan_o, .busy_o, .irq_o
  );
endmodule

// File: rtl/adc_list_dma_chk.sv
module adc_list_dma_chk
  import adc_dma_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                reg_we_i,
  input logic [SEL_W-1:0]    reg_sel_i,
  input logic [BYTE_W-1:0]   reg_wdata_i,
  input logic                mem_req_o,
  input logic                mem_we_o,
  input logic [ADDR_W-1:0]   mem_addr_o,
  input logic                conv_start_o,
  input logic                conv_done_i,
  input logic                busy_o,
  input logic                irq_o
);
  logic ctrl_wr, pending_q, wr_q;
  assign ctrl_wr = reg_we_i && (reg_sel_i == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      wr_q      <= 1'b0;
    end else begin
      wr_q <= mem_req_o && mem_we_o;
      if (conv_start_o) pending_q <= 1'b1;
      else if (conv_done_i || !busy_o) pending_q <= 1'b0;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !conv_start_o));

  a_r3_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_wdata_i[CTRL_EN] && !busy_o) |=> busy_o);

  a_r4_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  a_r5_no_start_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> !pending_q);

  a_r6_byte_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !wr_q && !(ctrl_wr && !reg_wdata_i[CTRL_EN]))
      |=> (mem_req_o && mem_we_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));

  a_r7_irq_at_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (!busy_o && !conv_start_o));

  a_r8_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !busy_o) |=> !irq_o);

  a_r9_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !reg_wdata_i[CTRL_EN]) |=> (!busy_o && !irq_o));
endmodule

bind adc_list_dma adc_list_dma_chk i_chk (.*);

// File: tb/test_adc_list_dma.sv
module test_adc_list_dma;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_N = 512;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic        timer_tick = 1'b0, ext_trig = 1'b0;
  logic        mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = '0;
  logic        conv_start, conv_done = 1'b0;
  logic [3:0]  conv_chan;
  logic [11:0] conv_data = '0;
  logic        busy, irq;

  adc_list_dma i_adc_list_dma (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .timer_tick_i(timer_tick), .ext_trig_i(ext_trig),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .conv_start_o(conv_start), .conv_chan_o(conv_chan),
    .conv_done_i(conv_done), .conv_data_i(conv_data),
    .busy_o(busy), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;

  // memory model with backdoor load port
  logic [7:0]  mem [MEM_N];
  logic        bd_we = 1'b0;
  logic [8:0]  bd_addr = '0;
  logic [7:0]  bd_data = '0;
  logic [14:0] exp_hi = '0;
  int          addr_bad = 0, wr_count = 0, rd_count = 0;
  logic [23:0] rd_log [64];

  always @(posedge clk) begin
    if (bd_we) mem[bd_addr] <= bd_data;
    if (mem_req) begin
      if (mem_addr[23:9] != exp_hi) addr_bad <= addr_bad + 1;
      if (mem_we) begin
        mem[mem_addr[8:0]] <= mem_wdata;
        wr_count <= wr_count + 1;
      end else begin
        mem_rdata <= mem[mem_addr[8:0]];
        rd_log[rd_count[5:0]] <= mem_addr;
        rd_count <= rd_count + 1;
      end
    end
  end

  // converter model
  int          conv_delay = 8, n_conv = 0, cnt = 0;
  logic [3:0]  chan_log [256];
  logic [11:0] data_log [256];
  logic [11:0] next_data;
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) begin
      next_data = 12'($urandom);
      chan_log[n_conv[7:0]] <= conv_chan;
      data_log[n_conv[7:0]] <= next_data;
      conv_data <= next_data;
      n_conv <= n_conv + 1;
      cnt <= conv_delay;
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) conv_done <= 1'b1;
    end
  end

  // timer tick generator
  int tick_period = 0, tick_cnt = 0;
  always @(posedge clk) begin
    tick_cnt   <= (tick_cnt + 1 >= tick_period) ? 0 : tick_cnt + 1;
    timer_tick <= (tick_period != 0) && (tick_cnt == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic set_base(input logic [23:0] b);
    exp_hi = b[23:9];
    wr_reg(2'd0, b[7:0]); wr_reg(2'd1, b[15:8]); wr_reg(2'd2, b[23:16]);
  endtask

  task automatic bd_write(input int a, input logic [7:0] d);
    @(negedge clk); bd_we = 1'b1; bd_addr = 9'(a); bd_data = d;
    @(negedge clk); bd_we = 1'b0;
  endtask

  logic [7:0] shadow [MEM_N];
  logic [3:0] lst [16];
  int n_ent;

  // k real channels, repeat of the last, then terminator
  task automatic load_list(input int base, input int k);
    n_ent = 0;
    for (int i = 0; i < k; i++) begin lst[n_ent] = 4'($urandom_range(0, 14)); n_ent++; end
    if (k > 0) begin lst[n_ent] = lst[k-1]; n_ent++; end
    lst[n_ent] = 4'hF; n_ent++;
    for (int i = 0; i < n_ent; i++) begin
      shadow[base+2*i]   = {lst[i], 4'($urandom)};
      shadow[base+2*i+1] = 8'($urandom);
      bd_write(base+2*i, shadow[base+2*i]);
      bd_write(base+2*i+1, shadow[base+2*i+1]);
    end
  endtask

  function automatic int exp_conversions();
    for (int i = 0; i < n_ent; i++)
      if (lst[i] == 4'hF || (i + 1 < n_ent && lst[i+1] == 4'hF)) return i;
    return n_ent;
  endfunction

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit && busy; i++) @(negedge clk);
  endtask

  task automatic verify_run(input int base, input int c0, input string tag);
    int k;
    k = exp_conversions();
    chk(n_conv - c0 == k, "R5 conversion count", n_conv - c0, k);
    chk(!busy && irq, "R7 stop busy/irq", {busy, irq}, 1);
    for (int i = 0; i < k; i++) begin
      chk(chan_log[8'(c0+i)] == lst[i], "R4 conv channel", chan_log[8'(c0+i)], lst[i]);
      chk(mem[base+2*i] == {lst[i], data_log[8'(c0+i)][11:8]}, "R6 high byte",
          mem[base+2*i], {lst[i], data_log[8'(c0+i)][11:8]});
      chk(mem[base+2*i+1] == data_log[8'(c0+i)][7:0], "R6 low byte",
          mem[base+2*i+1], data_log[8'(c0+i)][7:0]);
    end
    for (int i = 2*k; i < 2*n_ent; i++)
      chk(mem[base+i] == shadow[base+i], "R7 untouched tail", mem[base+i], shadow[base+i]);
    chk(addr_bad == 0, {tag, " R2 address upper bits"}, addr_bad, 0);
  endtask

  bit done = 0;
  initial begin
    int c0, w0, r0, base;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    chk(!busy && !irq && !mem_req && !conv_start, "R1 reset state",
        {busy, irq, mem_req, conv_start}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_req, "R1 idle after reset", {busy, mem_req}, 0);

    // random runs under timer triggering, ticks faster than conversions
    for (int run = 0; run < 3; run++) begin
      base = 2 * $urandom_range(0, 200);
      load_list(base, $urandom_range(1, 6));
      set_base({8'($urandom), 7'($urandom), 9'(base)});
      tick_period = $urandom_range(2, 5);
      conv_delay  = $urandom_range(6, 15);
      c0 = n_conv; r0 = rd_count;
      wr_reg(2'd3, 8'b0000_0011);
      chk(busy, "R3 busy after enable", busy, 1);
      wait_idle(5000);
      chk(rd_log[r0[5:0]] == {exp_hi, 9'(base)}, "R3 first read address",
          rd_log[r0[5:0]], {exp_hi, 9'(base)});
      chk(rd_log[6'(r0+1)] == {exp_hi, 9'(base)} + 24'd2, "R3 look-ahead address",
          rd_log[6'(r0+1)], {exp_hi, 9'(base)} + 24'd2);
      verify_run(base, c0, "random");
      tick_period = 0;
      wr_reg(2'd3, 8'h00);
      chk(!irq, "R8 irq cleared by control write", irq, 0);
    end

    // terminator as first entry: no conversion at all
    load_list(64, 0);
    set_base(24'h00_0040);
    tick_period = 3;
    c0 = n_conv;
    wr_reg(2'd3, 8'b0000_0011);
    wait_idle(100);
    verify_run(64, c0, "empty");
    repeat (10) @(negedge clk);
    chk(irq, "R8 irq held", irq, 1);
    tick_period = 0;

    // staged pointer bytes without page write keep the old base
    load_list(64, 1);
    wr_reg(2'd0, 8'h90); wr_reg(2'd1, 8'h01);
    tick_period = 4; c0 = n_conv; r0 = rd_count;
    wr_reg(2'd3, 8'b0000_0011);
    chk(!irq, "R8 irq cleared on restart", irq, 0);
    wait_idle(2000);
    chk(rd_log[r0[5:0]] == 24'h00_0040, "R2 staged bytes not committed",
        rd_log[r0[5:0]], 24'h00_0040);
    verify_run(64, c0, "staged");
    tick_period = 0;

    // disabled sources ignored, then single shot and external edge
    load_list(128, 3);
    set_base(24'h07_0080);
    wr_reg(2'd3, 8'b0000_0001);
    c0 = n_conv;
    tick_period = 2;
    repeat (5) @(negedge clk);
    ext_trig = 1'b1; repeat (6) @(negedge clk); ext_trig = 1'b0;
    repeat (20) @(negedge clk);
    chk(n_conv == c0 && busy, "R10 disabled sources ignored", n_conv - c0, 0);
    tick_period = 0;
    repeat (3) @(negedge clk);
    wr_reg(2'd3, 8'b0000_1001);
    chk(conv_start && conv_chan == lst[0], "R4 single-shot start pulse",
        {conv_start, conv_chan}, {1'b1, lst[0]});
    @(negedge clk);
    chk(!conv_start, "R4 start pulse one cycle", conv_start, 0);
    repeat (20) @(negedge clk);
    wr_reg(2'd3, 8'b0000_0101);
    ext_trig = 1'b1; repeat (4) @(negedge clk); ext_trig = 1'b0;
    repeat (20) @(negedge clk);
    chk(n_conv - c0 == 2, "R4 external edge trigger", n_conv - c0, 2);
    wr_reg(2'd3, 8'b0000_0011);
    tick_period = 3;
    wait_idle(2000);
    verify_run(128, c0, "mixed");
    tick_period = 0;

    // abort during a pending conversion
    load_list(200, 3);
    set_base(24'h00_00C8);
    conv_delay = 12;
    wr_reg(2'd3, 8'b0000_0001);
    repeat (4) @(negedge clk);
    c0 = n_conv;
    wr_reg(2'd3, 8'b0000_1001);
    w0 = wr_count;
    repeat (3) @(negedge clk);
    wr_reg(2'd3, 8'b0000_0000);
    chk(!busy, "R9 busy low after abort", busy, 0);
    tick_period = 2;
    repeat (40) @(negedge clk);
    chk(wr_count == w0 && n_conv == c0 + 1 && !irq, "R9 no activity after abort",
        wr_count - w0, 0);
    chk(mem[200] == shadow[200], "R9 entry not written", mem[200], shadow[200]);
    tick_period = 0;
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(negedge clk);
    if (!done) chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule